// File: doc/BRIEF.md
# Dense Classifier Layer with Argmax

This block is the final fully connected stage of an image classifier. It takes a flattened activation vector one element per handshake, multiplies each element by a constant weight matrix held in an on-chip ROM, and sums the products into one signed score per output class. No bias is added. Activations are unsigned and weights are signed two's complement.

A parameter selects how many multipliers are built. The shared variant has one multiplier and walks through all classes for each activation, stalling the input meanwhile. The per-output variant has one multiplier per class and takes a new activation every cycle. When the last element of a vector has been accumulated, the block presents all raw scores together with the index of the largest one and raises a one-cycle valid strobe. The scores stay linear. Argmax selects the same class that softmax would, so softmax is not built.

Top module: `dense_classifier`

## Requirements
- R1: Each group of N_IN accepted activations forms one vector, and the first activation accepted after reset is element 0. The weight for element i and class j is r = (5*i + 3*j + 1) mod 2^W_W, read as a W_W-bit two's-complement number. Score j is the sum over i of activation_i times weight(i,j), with no bias.
- R2: The scores are linear and signed, ACC_W bits each. Score j sits at `out_scores[j*ACC_W +: ACC_W]`.
- R3: `out_idx` is the class with the largest score. When scores tie, the lowest index wins.
- R4: `out_valid` is high for exactly one cycle per vector. `out_scores` and `out_idx` hold their values until the next strobe.
- R5: The accumulators restart at each new vector, so a result does not depend on earlier vectors.
- R6: In shared mode (SHARED=1), `in_ready` is low for exactly N_OUT cycles after each accepted activation. Data offered while `in_ready` is low is not taken.
- R7: In per-output mode (SHARED=0), `in_ready` stays high and one activation can be accepted every cycle.
- R8: `out_valid` rises 2 cycles after the edge that accepts a vector's last activation in per-output mode, and N_OUT+2 cycles after it in shared mode.
- R9: After reset, `out_valid` is 0, all scores are 0, `out_idx` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Activation offered |
| in_ready | output | 1 | Block can take an activation |
| in_data | input | A_W | Unsigned activation |
| out_valid | output | 1 | One-cycle result strobe |
| out_idx | output | IDX_W | Index of the winning class |
| out_scores | output | N_OUT*ACC_W | Packed signed class scores |

## Verification
Both multiplier variants are run with every vector a small configuration allows: all 3-element vectors of 3-bit activations against 6 classes with 2-bit weights. That configuration gives columns 0/4 and 1/5 identical weights, so ties arise naturally and the lowest-index rule is separated from a highest-index or last-seen rule. The all-zero vector ties every class. Vectors are sent back to back with no gap, which shows whether accumulators restart. In shared mode, the next element is offered during the stall, which exposes early acceptance. In per-output mode, idle cycles are inserted between elements of alternate vectors, so continuous and sparse streams are compared.

// File: rtl/dense_pkg.sv
package dense_pkg;

  // Constant weight for input element i and class j, as a signed integer.
  function automatic int weight_of(input int i, input int j, input int ww);
    int raw;
    raw = (5 * i + 3 * j + 1) % (1 << ww);
    if (raw >= (1 << (ww - 1))) return raw - (1 << ww);
    return raw;
  endfunction

endpackage

// File: rtl/dense_wrom.sv
module dense_wrom #(
  parameter int N_IN   = 16,
  parameter int N_OUT  = 43,
  parameter int W_W    = 8,
  parameter int SHARED = 1,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdata
);
  import dense_pkg::*;

  generate
    if (SHARED != 0) begin : g_elem
      // One weight per word, address = i*N_OUT + j.
      localparam int DEPTH = N_IN * N_OUT;
      logic [W_W-1:0] mem [DEPTH];
      initial begin
        for (int k = 0; k < DEPTH; k++)
          mem[k] = W_W'(weight_of(k / N_OUT, k % N_OUT, W_W));
      end
      always_ff @(posedge clk) rdata <= mem[addr];
    end else begin : g_row
      // One full row of class weights per word, address = i.
      logic [DATA_W-1:0] mem [N_IN];
      initial begin
        for (int i = 0; i < N_IN; i++)
          for (int j = 0; j < N_OUT; j++)
            mem[i][j*W_W +: W_W] = W_W'(weight_of(i, j, W_W));
      end
      always_ff @(posedge clk) rdata <= mem[addr];
    end
  endgenerate

endmodule

// File: rtl/dense_mac_bank.sv
module dense_mac_bank #(
  parameter int N_OUT  = 43,
  parameter int A_W    = 8,
  parameter int W_W    = 8,
  parameter int ACC_W  = 21,
  parameter int SHARED = 1,
  parameter int DATA_W = 8,
  parameter int JW     = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mac_en,
  input  logic                   mac_first,
  input  logic [JW-1:0]          mac_j,
  input  logic [A_W-1:0]         mac_act,
  input  logic [DATA_W-1:0]      wdata,
  output logic [N_OUT*ACC_W-1:0] acc_flat
);
  logic signed [ACC_W-1:0] acc_q [N_OUT];

  generate
    if (SHARED != 0) begin : g_one
      logic signed [A_W+W_W:0] prod;
      assign prod = $signed({1'b0, mac_act}) * $signed(wdata[W_W-1:0]);
      for (genvar j = 0; j < N_OUT; j++) begin : g_acc
        logic hit;
        assign hit = mac_en && (mac_j == JW'(j));
        always_ff @(posedge clk) begin
          if (rst) acc_q[j] <= '0;
          else if (hit) acc_q[j] <= (mac_first ? '0 : acc_q[j]) + ACC_W'(prod);
        end
        assign acc_flat[j*ACC_W +: ACC_W] = acc_q[j];
      end
    end else begin : g_many
      for (genvar j = 0; j < N_OUT; j++) begin : g_acc
        logic signed [A_W+W_W:0] prod;
        logic hit;
        assign prod = $signed({1'b0, mac_act}) * $signed(wdata[j*W_W +: W_W]);
        assign hit  = mac_en && (SHARED == 0 || mac_j == JW'(j));
        always_ff @(posedge clk) begin
          if (rst) acc_q[j] <= '0;
          else if (hit) acc_q[j] <= (mac_first ? '0 : acc_q[j]) + ACC_W'(prod);
        end
        assign acc_flat[j*ACC_W +: ACC_W] = acc_q[j];
      end
    end
  endgenerate

endmodule

// File: rtl/dense_argmax.sv
module dense_argmax #(
  parameter int N_OUT = 43,
  parameter int ACC_W = 21,
  parameter int IDX_W = 6
) (
  input  logic [N_OUT*ACC_W-1:0] scores,
  output logic [IDX_W-1:0]       best_idx
);
  logic signed [ACC_W-1:0] best_val;

  // Strict comparison keeps the earliest index on ties.
  always_comb begin
    best_idx = '0;
    best_val = $signed(scores[ACC_W-1:0]);
    for (int j = 1; j < N_OUT; j++) begin
      if ($signed(scores[j*ACC_W +: ACC_W]) > best_val) begin
        best_val = $signed(scores[j*ACC_W +: ACC_W]);
        best_idx = IDX_W'(j);
      end
    end
  end

endmodule

// File: rtl/dense_classifier.sv
module dense_classifier #(
  parameter int N_IN   = 16,
  parameter int N_OUT  = 43,
  parameter int A_W    = 8,
  parameter int W_W    = 8,
  parameter int SHARED = 1,
  parameter int ACC_W  = A_W + W_W + $clog2(N_IN) + 1,
  parameter int IDX_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [A_W-1:0]         in_data,
  output logic                   out_valid,
  output logic [IDX_W-1:0]       out_idx,
  output logic [N_OUT*ACC_W-1:0] out_scores
);
  localparam int IW     = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int EW     = (N_IN * N_OUT > 1) ? $clog2(N_IN * N_OUT) : 1;
  localparam int ADDR_W = (SHARED != 0) ? EW : IW;
  localparam int DATA_W = (SHARED != 0) ? W_W : N_OUT * W_W;

  logic              accept;
  logic [IW-1:0]     in_cnt;
  logic              issue_v, issue_first, issue_last;
  logic [IDX_W-1:0]  issue_j;
  logic [A_W-1:0]    issue_act;
  logic [ADDR_W-1:0] rom_addr;

  assign accept = in_valid && in_ready;

  // Element counter: frames the stream into vectors of N_IN.
  always_ff @(posedge clk) begin
    if (rst) in_cnt <= '0;
    else if (accept) in_cnt <= (int'(in_cnt) == N_IN - 1) ? '0 : in_cnt + 1'b1;
  end

  generate
    if (SHARED != 0) begin : g_seq
      logic             busy;
      logic [IW-1:0]    cur_i;
      logic [IDX_W-1:0] cur_j;
      logic [A_W-1:0]   cur_act;

      assign in_ready = !busy;

      always_ff @(posedge clk) begin
        if (rst) begin
          busy    <= 1'b0;
          cur_i   <= '0;
          cur_j   <= '0;
          cur_act <= '0;
        end else if (accept) begin
          busy    <= 1'b1;
          cur_i   <= in_cnt;
          cur_j   <= '0;
          cur_act <= in_data;
        end else if (busy) begin
          cur_j <= cur_j + 1'b1;
          if (int'(cur_j) == N_OUT - 1) busy <= 1'b0;
        end
      end

      assign issue_v     = busy;
      assign issue_j     = cur_j;
      assign issue_act   = cur_act;
      assign issue_first = (cur_i == '0);
      assign issue_last  = (int'(cur_i) == N_IN - 1) && (int'(cur_j) == N_OUT - 1);
      assign rom_addr    = ADDR_W'(int'(cur_i) * N_OUT + int'(cur_j));
    end else begin : g_par
      assign in_ready    = 1'b1;
      assign issue_v     = accept;
      assign issue_j     = '0;
      assign issue_act   = in_data;
      assign issue_first = (in_cnt == '0);
      assign issue_last  = (int'(in_cnt) == N_IN - 1);
      assign rom_addr    = ADDR_W'(in_cnt);
    end
  endgenerate

  // ROM read and the operands that travel with it.
  logic [DATA_W-1:0] wdata;
  logic              mac_en, mac_first, mac_last, done_q;
  logic [IDX_W-1:0]  mac_j;
  logic [A_W-1:0]    mac_act;

  dense_wrom #(
    .N_IN(N_IN), .N_OUT(N_OUT), .W_W(W_W), .SHARED(SHARED),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_wrom (
    .clk(clk), .addr(rom_addr), .rdata(wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mac_en    <= 1'b0;
      mac_first <= 1'b0;
      mac_last  <= 1'b0;
      mac_j     <= '0;
      mac_act   <= '0;
      done_q    <= 1'b0;
    end else begin
      mac_en    <= issue_v;
      mac_first <= issue_first;
      mac_last  <= issue_last;
      mac_j     <= issue_j;
      mac_act   <= issue_act;
      done_q    <= mac_en && mac_last;
    end
  end

  logic [N_OUT*ACC_W-1:0] acc_flat;
  logic [IDX_W-1:0]       best_idx;

  dense_mac_bank #(
    .N_OUT(N_OUT), .A_W(A_W), .W_W(W_W), .ACC_W(ACC_W),
    .SHARED(SHARED), .DATA_W(DATA_W), .JW(IDX_W)
  ) u_macs (
    .clk(clk), .rst(rst), .mac_en(mac_en), .mac_first(mac_first),
    .mac_j(mac_j), .mac_act(mac_act), .wdata(wdata), .acc_flat(acc_flat)
  );

  dense_argmax #(
    .N_OUT(N_OUT), .ACC_W(ACC_W), .IDX_W(IDX_W)
  ) u_argmax (
    .scores(acc_flat), .best_idx(best_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_idx    <= '0;
      out_scores <= '0;
    end else begin
      out_valid <= done_q;
      if (done_q) begin
        out_idx    <= best_idx;
        out_scores <= acc_flat;
      end
    end
  end

endmodule

// File: rtl/dense_classifier_chk.sv
module dense_classifier_chk #(
  parameter int N_OUT  = 43,
  parameter int ACC_W  = 21,
  parameter int IDX_W  = 6,
  parameter int SHARED = 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic [IDX_W-1:0]       out_idx,
  input logic [N_OUT*ACC_W-1:0] out_scores
);
  logic                    idx_ok;
  logic signed [ACC_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int j = 0; j < N_OUT; j++)
      if (int'(out_idx) == j) sel = $signed(out_scores[j*ACC_W +: ACC_W]);
    idx_ok = 1'b1;
    for (int j = 0; j < N_OUT; j++) begin
      if (j < int'(out_idx) && $signed(out_scores[j*ACC_W +: ACC_W]) >= sel) idx_ok = 1'b0;
      if (j > int'(out_idx) && $signed(out_scores[j*ACC_W +: ACC_W]) > sel)  idx_ok = 1'b0;
    end
  end

  AST_SHARED_STALL: assert property (@(posedge clk) disable iff (rst)
    (SHARED != 0 && in_valid && in_ready) |=> !in_ready); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_scores) && $stable(out_idx))); // R4
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_idx) < N_OUT)); // R3
  AST_IDX_IS_MAX: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> idx_ok); // R3

endmodule

bind dense_classifier dense_classifier_chk #(
  .N_OUT(N_OUT), .ACC_W(ACC_W), .IDX_W(IDX_W), .SHARED(SHARED)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_idx(out_idx), .out_scores(out_scores)
);

// File: tb/test_dense_classifier.sv
module test_dense_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 3;
  localparam int NO = 6;
  localparam int AW = 3;
  localparam int WW = 2;
  localparam int AC = AW + WW + $clog2(NI) + 1;
  localparam int IW = $clog2(NO);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic                iv   [2];
  logic [AW-1:0]       idat [2];
  logic                ir   [2];
  logic                ov   [2];
  logic [IW-1:0]       oi   [2];
  logic [NO*AC-1:0]    os   [2];

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // index 0: shared multiplier, index 1: one multiplier per class
  dense_classifier #(.N_IN(NI), .N_OUT(NO), .A_W(AW), .W_W(WW), .SHARED(1)) i_dense_classifier (
    .clk(clk), .rst(rst), .in_valid(iv[0]), .in_ready(ir[0]), .in_data(idat[0]),
    .out_valid(ov[0]), .out_idx(oi[0]), .out_scores(os[0]));

  dense_classifier #(.N_IN(NI), .N_OUT(NO), .A_W(AW), .W_W(WW), .SHARED(0)) i_dense_classifier_par (
    .clk(clk), .rst(rst), .in_valid(iv[1]), .in_ready(ir[1]), .in_data(idat[1]),
    .out_valid(ov[1]), .out_idx(oi[1]), .out_scores(os[1]));

  function automatic int wgt(input int i, input int j);
    int r;
    r = (5 * i + 3 * j + 1) % (1 << WW);
    return (r >= (1 << (WW - 1))) ? r - (1 << WW) : r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input int m, input logic [AW-1:0] a, output int stalls);
    iv[m] = 1'b1;
    idat[m] = a;
    stalls = 0;
    while (!ir[m]) begin
      @(negedge clk);
      stalls++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_vector(input int m, input int v, input bit gaps);
    logic [AW-1:0]    a [NI];
    logic [NO*AC-1:0] exp_s;
    logic [NO*AC-1:0] held;
    int best, bestv, stalls, lat;
    for (int i = 0; i < NI; i++) a[i] = AW'(v >> (i * AW));
    best = 0;
    bestv = 0;
    for (int j = 0; j < NO; j++) begin
      int s;
      s = 0;
      for (int i = 0; i < NI; i++) s += int'(a[i]) * wgt(i, j);
      exp_s[j*AC +: AC] = AC'(s);
      if (j == 0 || s > bestv) begin
        bestv = s;
        best = j;
      end
    end
    for (int i = 0; i < NI; i++) begin
      send(m, a[i], stalls);
      if (i > 0) begin
        if (m == 0) check(stalls == NO, "R6 ready low after accept", 64'(stalls), 64'(NO));
        else        check(stalls == 0, "R7 ready stays high", 64'(stalls), 64'd0);
      end
      if (gaps && i < NI - 1) begin
        iv[m] = 1'b0;
        @(negedge clk);
      end
    end
    iv[m] = 1'b0;
    lat = 0;
    while (!ov[m] && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(lat == ((m == 0) ? NO + 2 : 2), "R8 result latency", 64'(lat), 64'((m == 0) ? NO + 2 : 2));
    check(os[m] == exp_s, "R1 R2 R5 scores", 64'(os[m]), 64'(exp_s));
    check(int'(oi[m]) == best, "R3 argmax index", 64'(oi[m]), 64'(best));
    held = os[m];
    @(negedge clk);
    check(ov[m] == 1'b0, "R4 valid is one cycle", 64'(ov[m]), 64'd0);
    check(os[m] == held && int'(oi[m]) == best, "R4 result held", 64'(os[m]), 64'(held));
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      iv[i] = 1'b0;
      idat[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check(ov[m] == 1'b0, "R9 reset out_valid", 64'(ov[m]), 64'd0);
      check(os[m] == '0, "R9 reset scores", 64'(os[m]), 64'd0);
      check(oi[m] == '0, "R9 reset index", 64'(oi[m]), 64'd0);
      check(ir[m] == 1'b1, "R9 reset in_ready", 64'(ir[m]), 64'd1);
    end
    rst = 1'b0;
    @(negedge clk);
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < (1 << (NI * AW)); v++)
        run_vector(m, v, (m == 1) && v[0]);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule